// File: doc/BRIEF.md
# Interrupt Pending and Acknowledge Controller

This block accepts an encoded interrupt priority level on three active-low request lines and decides when a processor's exception sequencer should take an interrupt. It passes the request level through a synchronizer and then a recognition register. It compares the recognized level with the interrupt mask and raises a pending flag. At the next instruction boundary where no higher-priority exception waits, it opens an interrupt acknowledge bus cycle. It then resolves how the bus ends that cycle.

During the acknowledge cycle the controller drives the acknowledged level and samples four termination strobes: acknowledge, error, retry and autovector. It reports one of six results: wait, vectored, autovectored, spurious, retry or illegal. With the result it gives an 8-bit exception vector. A mode input chooses between native decoding and a compatibility decoding in which the retry strobe is not allowed. After an interrupt is taken, the sequencer has to report one instruction boundary before the controller recognizes another request.

The control flow is a four-state machine:
- `ST_IDLE`: waits for a request. The transition *request seen* goes to `ST_PEND`.
- `ST_PEND`: the level is latched and pending is raised. The transition *boundary free* goes to `ST_ACK`.
- `ST_ACK`: the acknowledge cycle is open. Wait, retry and illegal stay here. The transition *final termination* goes to `ST_HOLD`.
- `ST_HOLD`: the hold-off after a take. The transition *boundary seen* goes back to `ST_IDLE`.

Top module: `irq_ack_ctrl`

## Requirements
- R1: The request level is the bitwise inverse of `ipl_n`. A level above `mask_level` first shows as `irq_pending`=1 three clock edges after `ipl_n` changes, and `irq_pending` stays 0 after the second of those edges.
- R2: A level of 1 to 6 that is equal to or below `mask_level` never raises `irq_pending`. The compare is strictly greater-than.
- R3: `ack_active` rises only on an edge where `insn_boundary`=1 and `hi_pri_exc`=0 while the request is pending. `irq_pending` stays 1 for the whole acknowledge cycle and falls on the same edge that reports a final result (kind 1, 2 or 3). After reset, every output is 0.
- R4: After a final result, a request that is still present does not raise `irq_pending` again until one `insn_boundary` pulse has been taken. `irq_pending` then rises two edges after that boundary edge.
- R5: While the acknowledge cycle is open and acknowledge, error and retry are all 0, the cycle stays open and `res_valid` stays 0. Every result shows on `res_valid`/`res_kind`/`res_vector` for one cycle, on the edge after the strobes are sampled.
- R6: Acknowledge=1, error=0 and autovector=0 give `res_kind`=1 (vectored), with `res_vector` equal to `bus_data`.
- R7: Acknowledge=1, error=0 and autovector=1 give `res_kind`=2 (autovectored), with `res_vector` = 24 + level. `bus_data` has no effect.
- R8: Error=1 with retry=0 gives `res_kind`=3 (spurious) with `res_vector`=24, whatever the acknowledge and autovector strobes are.
- R9: In native mode (`compat_mode`=0), error=1 with retry=1 gives `res_kind`=4 (retry). The cycle stays open and `irq_pending` stays 1. Retry without error has no effect.
- R10: In compatibility mode (`compat_mode`=1), any sampled cycle with retry=1 gives `res_kind`=5 (illegal), and the cycle stays open.
- R11: Level 7 is recognized even when `mask_level`=7, but only after a transition into level 7. A level 7 that is held does not raise `irq_pending` a second time.
- R12: `ack_level` shows the latched level while `ack_active`=1 and is 0 at all other times. It stays constant throughout an acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ipl_n | input | 3 | Encoded interrupt priority request, active low |
| mask_level | input | 3 | Interrupt mask from the status register |
| insn_boundary | input | 1 | Sequencer reports an instruction boundary |
| hi_pri_exc | input | 1 | A higher-priority exception is waiting |
| compat_mode | input | 1 | 1 selects compatibility termination decoding |
| bus_ok | input | 1 | Transfer acknowledge strobe |
| bus_err | input | 1 | Transfer error strobe |
| bus_retry | input | 1 | Retry strobe |
| bus_auto | input | 1 | Autovector strobe |
| bus_data | input | 8 | Data bus bits carrying the vector number |
| irq_pending | output | 1 | Interrupt pending status |
| ack_active | output | 1 | Acknowledge cycle open |
| ack_level | output | 3 | Level being acknowledged |
| res_valid | output | 1 | One-cycle result strobe |
| res_kind | output | 3 | Result code: 0 none, 1 vectored, 2 autovectored, 3 spurious, 4 retry, 5 illegal |
| res_vector | output | 8 | Exception vector for final results |

## Verification
Each result has its own latency.
- A new request level shows on `irq_pending` after exactly three edges. The bench samples at the falling edge after the second edge to see it still low, and after the third edge to see it high.
- An instruction boundary driven before an edge opens the acknowledge cycle on that edge.
- Termination strobes driven before an edge give the result, the fall of pending and the close of the cycle on that same edge.
- After a take, pending returns two edges after the boundary edge.

The bench drives every input at the falling edge and samples one falling edge after each rising edge, so every check falls in the cycle in which the registered output changes. Random termination patterns are compared against a bench function that decodes them with the priority given in the requirements.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_ACK  = 2'd2,
        ST_HOLD = 2'd3
    } ctl_state_t;

    typedef enum logic [2:0] {
        RK_NONE    = 3'd0,
        RK_VECTOR  = 3'd1,
        RK_AUTO    = 3'd2,
        RK_SPUR    = 3'd3,
        RK_RETRY   = 3'd4,
        RK_ILLEGAL = 3'd5
    } res_kind_t;

endpackage

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
    parameter int unsigned LVL_W      = 3,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] ipl_n,
    output logic [LVL_W-1:0] rec_level,
    output logic             top_edge
);
    localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};

    // stage 0 is the synchronizer; the last stage is the recognition register
    logic [SYNC_DEPTH-1:0][LVL_W-1:0] stg;
    logic [LVL_W-1:0]                 prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg    <= '0;
            prev_q <= '0;
        end else begin
            stg    <= {stg[SYNC_DEPTH-2:0], ~ipl_n};
            prev_q <= stg[SYNC_DEPTH-1];
        end
    end

    assign rec_level = stg[SYNC_DEPTH-1];
    assign top_edge  = (rec_level == LVL_TOP) && (prev_q != LVL_TOP);

endmodule

// File: rtl/irq_term_decode.sv
module irq_term_decode
    import irq_ack_pkg::*;
(
    input  logic      compat_mode,
    input  logic      bus_ok,
    input  logic      bus_err,
    input  logic      bus_retry,
    input  logic      bus_auto,
    output res_kind_t kind,
    output logic      final_o
);
    always_comb begin
        if (compat_mode && bus_retry) begin
            kind = RK_ILLEGAL;
        end else if (bus_err && bus_retry) begin
            kind = RK_RETRY;
        end else if (bus_err) begin
            kind = RK_SPUR;
        end else if (bus_ok) begin
            kind = bus_auto ? RK_AUTO : RK_VECTOR;
        end else begin
            kind = RK_NONE;
        end
    end

    assign final_o = (kind == RK_VECTOR) || (kind == RK_AUTO) || (kind == RK_SPUR);

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_ack_pkg::*;
#(
    parameter int unsigned LVL_W      = 3,
    parameter int unsigned VEC_W      = 8,
    parameter int unsigned SYNC_DEPTH = 2,
    parameter int unsigned AUTO_BASE  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] ipl_n,
    input  logic [LVL_W-1:0] mask_level,
    input  logic             insn_boundary,
    input  logic             hi_pri_exc,
    input  logic             compat_mode,
    input  logic             bus_ok,
    input  logic             bus_err,
    input  logic             bus_retry,
    input  logic             bus_auto,
    input  logic [VEC_W-1:0] bus_data,
    output logic             irq_pending,
    output logic             ack_active,
    output logic [LVL_W-1:0] ack_level,
    output logic             res_valid,
    output logic [2:0]       res_kind,
    output logic [VEC_W-1:0] res_vector
);
    localparam logic [LVL_W-1:0] LVL_TOP  = {LVL_W{1'b1}};
    localparam logic [VEC_W-1:0] VEC_BASE = VEC_W'(AUTO_BASE);

    logic [LVL_W-1:0] rec_level;
    logic             top_edge;
    res_kind_t        term_kind;
    logic             term_final;

    ctl_state_t       state_q, state_d;
    logic [LVL_W-1:0] lvl_q;
    logic             nmi_armed;
    logic             nmi_req, std_req;

    irq_level_sync #(
        .LVL_W      (LVL_W),
        .SYNC_DEPTH (SYNC_DEPTH)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ipl_n     (ipl_n),
        .rec_level (rec_level),
        .top_edge  (top_edge)
    );

    irq_term_decode u_dec (
        .compat_mode (compat_mode),
        .bus_ok      (bus_ok),
        .bus_err     (bus_err),
        .bus_retry   (bus_retry),
        .bus_auto    (bus_auto),
        .kind        (term_kind),
        .final_o     (term_final)
    );

    // top level is edge-armed; lower levels compare strictly against the mask
    assign nmi_req = top_edge || nmi_armed;
    assign std_req = (rec_level != LVL_TOP) && (rec_level > mask_level);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (nmi_req || std_req)             state_d = ST_PEND;
            ST_PEND: if (insn_boundary && !hi_pri_exc)   state_d = ST_ACK;
            ST_ACK:  if (term_final)                     state_d = ST_HOLD;
            ST_HOLD: if (insn_boundary)                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            lvl_q     <= '0;
            nmi_armed <= 1'b0;
        end else begin
            state_q   <= state_d;
            nmi_armed <= (nmi_armed || top_edge) && (state_q != ST_IDLE);
            if (state_q == ST_IDLE && state_d == ST_PEND) begin
                lvl_q <= nmi_req ? LVL_TOP : rec_level;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pending <= 1'b0;
            res_valid   <= 1'b0;
            res_kind    <= RK_NONE;
            res_vector  <= '0;
        end else begin
            irq_pending <= (state_d == ST_PEND) || (state_d == ST_ACK);
            res_valid   <= (state_q == ST_ACK) && (term_kind != RK_NONE);
            res_kind    <= (state_q == ST_ACK) ? term_kind : RK_NONE;
            res_vector  <= '0;
            if (state_q == ST_ACK) begin
                unique case (term_kind)
                    RK_VECTOR: res_vector <= bus_data;
                    RK_AUTO:   res_vector <= VEC_BASE + VEC_W'(lvl_q);
                    RK_SPUR:   res_vector <= VEC_BASE;
                    default:   res_vector <= '0;
                endcase
            end
        end
    end

    assign ack_active = (state_q == ST_ACK);
    assign ack_level  = ack_active ? lvl_q : '0;

    AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_active) |-> $past(insn_boundary && !hi_pri_exc));                  // R3
    AST_ACK_HOLDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ack_active |-> irq_pending);                                                 // R3
    AST_PEND_FALLS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_pending) |-> $past(ack_active));                                   // R3
    AST_HOLD_BLOCKS_RECOG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !insn_boundary) |=> !irq_pending);                    // R4
    AST_RESULT_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(ack_active));                                            // R5
    AST_RETRY_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == RK_RETRY) |-> (ack_active && irq_pending));        // R9
    AST_ILLEGAL_ONLY_COMPAT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == RK_ILLEGAL) |-> $past(compat_mode));               // R10
    AST_LEVEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_active && $past(ack_active)) |-> $stable(ack_level));                   // R12

endmodule

// File: tb/irq_ack_ctrl_test.sv
module irq_ack_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ipl_n = 3'b111;
    logic [2:0] mask_level = 3'd0;
    logic       insn_boundary = 1'b0, hi_pri_exc = 1'b0, compat_mode = 1'b0;
    logic       bus_ok = 1'b0, bus_err = 1'b0, bus_retry = 1'b0, bus_auto = 1'b0;
    logic [7:0] bus_data = 8'd0;
    logic       irq_pending, ack_active, res_valid;
    logic [2:0] ack_level, res_kind;
    logic [7:0] res_vector;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    irq_ack_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ipl_n(ipl_n), .mask_level(mask_level),
        .insn_boundary(insn_boundary), .hi_pri_exc(hi_pri_exc), .compat_mode(compat_mode),
        .bus_ok(bus_ok), .bus_err(bus_err), .bus_retry(bus_retry), .bus_auto(bus_auto),
        .bus_data(bus_data), .irq_pending(irq_pending), .ack_active(ack_active),
        .ack_level(ack_level), .res_valid(res_valid), .res_kind(res_kind),
        .res_vector(res_vector)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_kind(bit c, bit ok, bit err, bit rt, bit au);
        if (c && rt)    return 5;
        if (err && rt)  return 4;
        if (err)        return 3;
        if (ok)         return au ? 2 : 1;
        return 0;
    endfunction

    function automatic int exp_vec(int k, int lvl, int data);
        if (k == 1) return data;
        if (k == 2) return 24 + lvl;
        if (k == 3) return 24;
        return 0;
    endfunction

    function automatic string kind_tag(int k);
        case (k)
            1: return "R6 vectored";
            2: return "R7 autovectored";
            3: return "R8 spurious";
            4: return "R9 retry";
            5: return "R10 illegal";
            default: return "R5 wait";
        endcase
    endfunction

    // change level from 0 and check the three-edge recognition latency
    task automatic raise(input int lvl, input int msk, input bit expect_pend);
        ipl_n = ~3'(lvl);
        mask_level = 3'(msk);
        tick; tick;
        chk("R1 pending low before third edge", irq_pending, 0);
        tick;
        chk(expect_pend ? "R1 pending after third edge" : "R2 masked level", irq_pending, expect_pend);
    endtask

    task automatic enter_ack(input int lvl);
        insn_boundary = 1'b1;
        tick;
        insn_boundary = 1'b0;
        chk("R3 ack opens at boundary", ack_active, 1);
        chk("R3 pending held in ack", irq_pending, 1);
        chk("R12 ack_level", ack_level, lvl);
    endtask

    task automatic strobe(input int lvl, input bit ok, input bit err, input bit rt,
                          input bit au, input int data, output bit fin);
        int k;
        k = exp_kind(compat_mode, ok, err, rt, au);
        bus_ok = ok; bus_err = err; bus_retry = rt; bus_auto = au; bus_data = 8'(data);
        tick;
        bus_ok = 1'b0; bus_err = 1'b0; bus_retry = 1'b0; bus_auto = 1'b0;
        fin = (k >= 1 && k <= 3);
        chk({kind_tag(k), " res_valid"}, res_valid, (k != 0) ? 1 : 0);
        chk({kind_tag(k), " res_kind"}, res_kind, k);
        if (fin) chk({kind_tag(k), " res_vector"}, res_vector, exp_vec(k, lvl, data));
        chk({kind_tag(k), " R3 ack open"}, ack_active, fin ? 0 : 1);
        chk({kind_tag(k), " R3 pending"}, irq_pending, fin ? 0 : 1);
        chk("R12 ack_level", ack_level, fin ? 0 : lvl);
    endtask

    task automatic settle;
        ipl_n = 3'b111;
        repeat (3) tick;
        insn_boundary = 1'b1;
        tick;
        insn_boundary = 1'b0;
        tick;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit fin;
        void'($urandom(32'd5150));
        repeat (2) tick;
        rst_n = 1'b1;
        tick;
        chk("R3 reset pending", irq_pending, 0);
        chk("R3 reset ack_active", ack_active, 0);
        chk("R3 reset res_valid", res_valid, 0);
        chk("R12 reset ack_level", ack_level, 0);

        // R2: equal to mask is masked, then above mask is taken (R1)
        raise(4, 4, 0);
        ipl_n = 3'b111; repeat (3) tick;
        raise(4, 3, 1);

        // R3: boundary blocked by higher-priority exception
        insn_boundary = 1'b1; hi_pri_exc = 1'b1;
        tick;
        insn_boundary = 1'b0; hi_pri_exc = 1'b0;
        chk("R3 blocked by higher exception", ack_active, 0);
        chk("R3 still pending", irq_pending, 1);
        enter_ack(4);
        strobe(4, 0, 0, 0, 0, 8'h11, fin);   // R5 wait
        strobe(4, 0, 0, 1, 0, 8'h22, fin);   // R9 retry alone ignored -> wait
        strobe(4, 0, 1, 1, 0, 8'h33, fin);   // R9 retry
        strobe(4, 1, 0, 1, 0, 8'hA5, fin);   // R6 vectored (retry ignored)

        // R4: hold-off until a boundary, level 4 still requested
        for (int i = 0; i < 4; i++) begin
            tick;
            chk("R4 no recognition before boundary", irq_pending, 0);
        end
        insn_boundary = 1'b1;
        tick;
        insn_boundary = 1'b0;
        chk("R4 pending low on boundary edge", irq_pending, 0);
        tick;
        chk("R4 pending two edges after boundary", irq_pending, 1);
        enter_ack(4);
        compat_mode = 1'b1;
        strobe(4, 1, 0, 1, 0, 8'h44, fin);   // R10 illegal
        strobe(4, 1, 0, 0, 1, 8'h77, fin);   // R7 autovector, data ignored
        compat_mode = 1'b0;
        settle;

        // R8: spurious wins over acknowledge and autovector
        raise(2, 0, 1);
        enter_ack(2);
        strobe(2, 1, 1, 0, 1, 8'h5A, fin);
        settle;

        // R11: level 7 with mask 7, edge only
        raise(7, 7, 1);
        enter_ack(7);
        strobe(7, 1, 0, 0, 0, 8'hC3, fin);
        insn_boundary = 1'b1;
        tick;
        insn_boundary = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick;
            chk("R11 held level 7 not re-recognized", irq_pending, 0);
        end
        settle;
        raise(7, 7, 1);
        enter_ack(7);
        strobe(7, 0, 0, 0, 1, 8'h00, fin);   // R5 wait: autovector alone
        strobe(7, 0, 1, 0, 0, 8'h00, fin);   // R8 spurious
        settle;

        // random mix
        for (int it = 0; it < 40; it++) begin
            int lvl, msk;
            lvl = int'($urandom_range(1, 6));
            msk = int'($urandom_range(0, 6));
            compat_mode = 1'($urandom_range(0, 1));
            raise(lvl, msk, lvl > msk);
            if (lvl > msk) begin
                enter_ack(lvl);
                for (int n = 0; n < 8; n++) begin
                    bit ok, err, rt, au;
                    ok = 1'($urandom_range(0, 1));
                    err = 1'($urandom_range(0, 1));
                    rt = 1'($urandom_range(0, 1));
                    au = 1'($urandom_range(0, 1));
                    if (n == 7) begin ok = 1'b1; err = 1'b0; rt = 1'b0; end
                    strobe(lvl, ok, err, rt, au, int'($urandom_range(0, 255)), fin);
                    if (fin) break;
                end
                settle;
            end else begin
                ipl_n = 3'b111;
                repeat (3) tick;
            end
        end
        compat_mode = 1'b0;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule